// File: doc/BRIEF.md
# I2C Masked Multi-Address Slave Matcher

This block decides whether the local device is being addressed on an I2C bus. A bit-level shifter feeds it a pulse for each START or repeated START, plus a pulse when a byte has been fully shifted in, with the byte beside that pulse. The block compares only the first byte after each START against four programmable 7-bit slave addresses. Each address has its own 7-bit don't-care mask. The block also recognises the general call address, which it always compares on all seven bits and never masks.

From the comparison the block registers four results: an address-match flag, the index of the matching address register, a general-call flag, and an acknowledge decision for the shifter. It keeps the last received byte, so software can read the actual address that caused a match. When the device is driving a transfer as master it does not match the address byte it sends itself. If arbitration is lost it acts as a slave at once and can match its own addresses in the same transfer. A 32-bit word-indexed register bus reaches the address, mask and data registers.

Top module: `i2c_addr_matcher`

## Requirements
- R1: After reset, `addrMatch`, `genCallMatch`, `ackAddr` and `matchIdx` are 0, and every address, mask and data register reads 0.
- R2: Register word index 0..3 is address register n. Bits 7:1 hold the 7-bit address and bit 0 is the general call enable. Bits 31:8 ignore writes and read 0.
- R3: Register word index 4..7 is mask register n. Only bits 7:1 are stored. Bits 31:8 and bit 0 ignore writes and always read 0.
- R4: The received bits 7:1 are compared with address register bits 7:1, and received bit 0 (read/write) plays no part. A mask bit of 1 makes that bit don't-care, and a mask bit of 0 demands equality.
- R5: A received address field of 0000000 sets `genCallMatch` exactly when at least one address register has bit 0 set, whatever the masks hold. That field never sets `addrMatch`.
- R6: When several address registers match, `matchIdx` gives the lowest-numbered one. `matchIdx` is 0 whenever `addrMatch` is 0.
- R7: Register word index 8 reads the last byte delivered with `byteDone`, in bits 7:0.
- R8: Only the first byte after a START is compared. Later bytes leave the match outputs unchanged.
- R9: `ackAddr` is 1 only if `addrMatch` or `genCallMatch` is 1 and `ackEnable` was 1 when the byte completed. With `ackEnable` at 0, no address is acknowledged.
- R10: While `masterOwn` is 1 the address byte is not compared, unless `arbLost` pulsed after the START. In that case the byte is compared as a slave.
- R11: The match outputs take their new values one cycle after the `byteDone` edge. They clear to 0 one cycle after the `startSeen` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 4 | Register word index |
| regWrEn | input | 1 | Register write strobe |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |
| startSeen | input | 1 | START or repeated START pulse from the shifter |
| byteDone | input | 1 | Byte complete pulse from the shifter |
| rxByte | input | 8 | Shifted byte, valid with `byteDone` |
| ackEnable | input | 1 | Assert-acknowledge enable |
| masterOwn | input | 1 | Device is driving the current transfer as master |
| arbLost | input | 1 | Arbitration lost pulse |
| addrMatch | output | 1 | A slave address register matched |
| matchIdx | output | 2 | Index of the lowest matching address register |
| genCallMatch | output | 1 | General call recognised |
| ackAddr | output | 1 | Acknowledge the address byte |

## Verification
Every match result is registered once. It is due in the cycle after the edge that samples `byteDone`, and it clears in the cycle after the edge that samples `startSeen`. The bench drives each strobe on a falling edge for a single cycle and reads the outputs on the next falling edge, which is exactly one register stage later. Register reads are combinational, so the bench samples them a short delay after setting the index. Expected values come from a bench function that applies the masks, the general call rule and the lowest-index rule.

// File: rtl/addr_match_pkg.sv
`timescale 1ns/1ps
package addr_match_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic evalAddr;    // compare the byte now completing
    logic clearMatch;  // new transfer: drop previous result
    logic captureByte; // latch the shifted byte
  } ctrlStrobe_t;
endpackage

// File: rtl/addr_match_ctrl.sv
`timescale 1ns/1ps
module addr_match_ctrl
  import addr_match_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startSeen,
  input  logic        byteDone,
  input  logic        masterOwn,
  input  logic        arbLost,
  output ctrlStrobe_t strobe
);
  logic expectAddr;   // next completed byte is the address byte
  logic arbLostSeen;  // arbitration lost since the last START
  logic actingMaster;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      expectAddr  <= 1'b0;
      arbLostSeen <= 1'b0;
    end else if (startSeen) begin
      expectAddr  <= 1'b1;
      arbLostSeen <= 1'b0;
    end else begin
      if (byteDone) expectAddr  <= 1'b0;
      if (arbLost)  arbLostSeen <= 1'b1;
    end
  end

  assign actingMaster = masterOwn && !arbLostSeen && !arbLost;

  always_comb begin
    strobe.clearMatch  = startSeen;
    strobe.captureByte = byteDone;
    strobe.evalAddr    = byteDone && expectAddr && !startSeen && !actingMaster;
  end
endmodule

// File: rtl/addr_match_dp.sv
`timescale 1ns/1ps
module addr_match_dp
  import addr_match_pkg::*;
#(
  parameter int NUM_ADDR  = 4,
  parameter int ADDR_BITS = 7,
  parameter int DATA_W    = 32,
  parameter int REG_AW    = 4,
  localparam int IDX_W    = (NUM_ADDR > 1) ? $clog2(NUM_ADDR) : 1,
  localparam int BYTE_W   = ADDR_BITS + 1
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              ackEnable,
  input  ctrlStrobe_t       strobe,
  output logic              addrMatch,
  output logic [IDX_W-1:0]  matchIdx,
  output logic              genCallMatch,
  output logic              ackAddr
);
  localparam int ADDR_BASE = 0;
  localparam int MASK_BASE = NUM_ADDR;
  localparam int DATA_IDX  = 2 * NUM_ADDR;

  logic [BYTE_W-1:0]    slvAddr [NUM_ADDR];
  logic [ADDR_BITS-1:0] slvMask [NUM_ADDR];
  logic [BYTE_W-1:0]    dataReg;
  logic [NUM_ADDR-1:0]  hit;
  logic [NUM_ADDR-1:0]  gcEn;
  logic                 rxIsGc;
  logic                 anyHit;
  logic [IDX_W-1:0]     lowIdx;
  logic                 unusedWrHi;

  assign unusedWrHi = ^regWdata[DATA_W-1:BYTE_W];

  for (genvar i = 0; i < NUM_ADDR; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slvAddr[i] <= '0;
        slvMask[i] <= '0;
      end else if (regWrEn) begin
        if (regAddr == REG_AW'(ADDR_BASE + i)) slvAddr[i] <= regWdata[BYTE_W-1:0];
        if (regAddr == REG_AW'(MASK_BASE + i)) slvMask[i] <= regWdata[BYTE_W-1:1];
      end
    end
    // masked compare of address field, bit 0 of received byte is R/W
    assign hit[i]  = !rxIsGc &&
                     (((rxByte[BYTE_W-1:1] ^ slvAddr[i][BYTE_W-1:1]) & ~slvMask[i]) == '0);
    assign gcEn[i] = slvAddr[i][0];
  end

  assign rxIsGc = (rxByte[BYTE_W-1:1] == '0);
  assign anyHit = |hit;

  always_comb begin
    lowIdx = '0;
    for (int i = NUM_ADDR - 1; i >= 0; i--) begin
      if (hit[i]) lowIdx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg <= '0;
    end else if (strobe.captureByte) begin
      dataReg <= rxByte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clearMatch) begin
      addrMatch    <= 1'b0;
      matchIdx     <= '0;
      genCallMatch <= 1'b0;
      ackAddr      <= 1'b0;
    end else if (strobe.evalAddr) begin
      addrMatch    <= anyHit;
      matchIdx     <= lowIdx;
      genCallMatch <= rxIsGc && (|gcEn);
      ackAddr      <= ackEnable && (anyHit || (rxIsGc && (|gcEn)));
    end
  end

  always_comb begin
    regRdata = '0;
    for (int i = 0; i < NUM_ADDR; i++) begin
      if (regAddr == REG_AW'(ADDR_BASE + i)) regRdata[BYTE_W-1:0] = slvAddr[i];
      if (regAddr == REG_AW'(MASK_BASE + i)) regRdata[BYTE_W-1:1] = slvMask[i];
    end
    if (regAddr == REG_AW'(DATA_IDX)) regRdata[BYTE_W-1:0] = dataReg;
  end
endmodule

// File: rtl/i2c_addr_matcher.sv
`timescale 1ns/1ps
module i2c_addr_matcher
  import addr_match_pkg::*;
#(
  parameter int NUM_ADDR  = 4,
  parameter int ADDR_BITS = 7,
  parameter int DATA_W    = 32,
  parameter int REG_AW    = 4,
  localparam int IDX_W    = (NUM_ADDR > 1) ? $clog2(NUM_ADDR) : 1,
  localparam int BYTE_W   = ADDR_BITS + 1
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              startSeen,
  input  logic              byteDone,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              ackEnable,
  input  logic              masterOwn,
  input  logic              arbLost,
  output logic              addrMatch,
  output logic [IDX_W-1:0]  matchIdx,
  output logic              genCallMatch,
  output logic              ackAddr
);
  ctrlStrobe_t strobe;

  addr_match_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startSeen(startSeen), .byteDone(byteDone),
    .masterOwn(masterOwn), .arbLost(arbLost), .strobe(strobe)
  );

  addr_match_dp #(
    .NUM_ADDR(NUM_ADDR), .ADDR_BITS(ADDR_BITS), .DATA_W(DATA_W), .REG_AW(REG_AW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWdata(regWdata), .regRdata(regRdata), .rxByte(rxByte),
    .ackEnable(ackEnable), .strobe(strobe), .addrMatch(addrMatch),
    .matchIdx(matchIdx), .genCallMatch(genCallMatch), .ackAddr(ackAddr)
  );
endmodule

// File: rtl/addr_match_checker.sv
`timescale 1ns/1ps
module addr_match_checker #(
  parameter int NUM_ADDR = 4,
  parameter int DATA_W   = 32,
  parameter int REG_AW   = 4,
  parameter int IDX_W    = 2
)(
  input logic              clk,
  input logic              rstN,
  input logic [REG_AW-1:0] regAddr,
  input logic [DATA_W-1:0] regRdata,
  input logic              startSeen,
  input logic              byteDone,
  input logic              ackEnable,
  input logic              addrMatch,
  input logic [IDX_W-1:0]  matchIdx,
  input logic              genCallMatch,
  input logic              ackAddr
);
  localparam int MASK_BASE = NUM_ADDR;
  localparam int DATA_IDX  = 2 * NUM_ADDR;

  assert_mask_unused_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr >= REG_AW'(MASK_BASE) && regAddr < REG_AW'(DATA_IDX)) |->
      (regRdata[DATA_W-1:8] == '0 && regRdata[0] == 1'b0));

  assert_gc_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(addrMatch && genCallMatch));

  assert_idx_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    !addrMatch |-> (matchIdx == '0));

  assert_ack_needs_match_R9: assert property (@(posedge clk) disable iff (!rstN)
    ackAddr |-> (addrMatch || genCallMatch));

  assert_ack_enable_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackAddr) |-> $past(ackEnable));

  assert_clear_on_start_R11: assert property (@(posedge clk) disable iff (!rstN)
    startSeen |=> (!addrMatch && !genCallMatch && !ackAddr));

  assert_rise_after_byte_R11: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(addrMatch) || $rose(genCallMatch)) |-> $past(byteDone));
endmodule

bind i2c_addr_matcher addr_match_checker #(
  .NUM_ADDR(NUM_ADDR), .DATA_W(DATA_W), .REG_AW(REG_AW), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regRdata(regRdata),
  .startSeen(startSeen), .byteDone(byteDone), .ackEnable(ackEnable),
  .addrMatch(addrMatch), .matchIdx(matchIdx), .genCallMatch(genCallMatch),
  .ackAddr(ackAddr)
);

// File: tb/i2c_addr_matcher_bench.sv
`timescale 1ns/1ps
module i2c_addr_matcher_bench;
  localparam int NA = 4;

  logic        clk = 1'b0;
  logic        rstN;
  logic [3:0]  regAddr;
  logic        regWrEn;
  logic [31:0] regWdata;
  logic [31:0] regRdata;
  logic        startSeen, byteDone, ackEnable, masterOwn, arbLost;
  logic [7:0]  rxByte;
  logic        addrMatch, genCallMatch, ackAddr;
  logic [1:0]  matchIdx;

  int total = 0;
  int fails = 0;
  bit done = 0;

  logic [7:0] mAddr [NA];
  logic [6:0] mMask [NA];

  always #2.5 clk = ~clk;

  i2c_addr_matcher u_i2c_addr_matcher (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWdata(regWdata), .regRdata(regRdata), .startSeen(startSeen),
    .byteDone(byteDone), .rxByte(rxByte), .ackEnable(ackEnable),
    .masterOwn(masterOwn), .arbLost(arbLost), .addrMatch(addrMatch),
    .matchIdx(matchIdx), .genCallMatch(genCallMatch), .ackAddr(ackAddr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // packed view of the four match outputs: {ack, gc, match, idx[1:0]}
  function automatic logic [31:0] outs();
    return {27'd0, ackAddr, genCallMatch, addrMatch, matchIdx};
  endfunction

  function automatic logic [31:0] model(input logic [7:0] rx, input logic ae);
    logic hitAny = 1'b0;
    logic [1:0] idx = 2'd0;
    logic gcOn = 1'b0;
    logic gc;
    for (int i = NA - 1; i >= 0; i--) begin
      if (rx[7:1] != 7'd0 && ((rx[7:1] ^ mAddr[i][7:1]) & ~mMask[i]) == 7'd0) begin
        hitAny = 1'b1;
        idx = 2'(i);
      end
      if (mAddr[i][0]) gcOn = 1'b1;
    end
    gc = (rx[7:1] == 7'd0) && gcOn;
    return {27'd0, ae && (hitAny || gc), gc, hitAny, idx};
  endfunction

  task automatic regWr(input int idx, input logic [31:0] d);
    @(negedge clk);
    regAddr = 4'(idx); regWdata = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    if (idx < NA) mAddr[idx] = d[7:0];
    else if (idx < 2 * NA) mMask[idx - NA] = d[7:1];
  endtask

  task automatic regRd(input int idx, output logic [31:0] d);
    regAddr = 4'(idx);
    #1;
    d = regRdata;
  endtask

  // START, optional arbitration loss, then the address byte; returns at the
  // falling edge one cycle after byteDone was sampled
  task automatic addrPhase(input logic [7:0] rx, input bit lose);
    @(negedge clk); startSeen = 1'b1;
    @(negedge clk); startSeen = 1'b0;
    if (lose) begin
      arbLost = 1'b1;
      @(negedge clk); arbLost = 1'b0;
    end
    rxByte = rx; byteDone = 1'b1;
    @(negedge clk); byteDone = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [7:0] rx;
    logic [31:0] hold;
    void'($urandom(32'h5eed_1234));
    rstN = 1'b0; regAddr = '0; regWrEn = 1'b0; regWdata = '0;
    startSeen = 1'b0; byteDone = 1'b0; rxByte = '0; ackEnable = 1'b1;
    masterOwn = 1'b0; arbLost = 1'b0;
    for (int i = 0; i < NA; i++) begin mAddr[i] = '0; mMask[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 outputs", outs(), 32'd0);
    for (int i = 0; i <= 2 * NA; i++) begin
      regRd(i, rd);
      check("R1 regs", rd, 32'd0);
    end

    // R2/R3 field layout
    regWr(1, 32'hFFFF_FFFF);
    regRd(1, rd); check("R2 addr field", rd, 32'h0000_00FF);
    regWr(NA + 2, 32'hFFFF_FFFF);
    regRd(NA + 2, rd); check("R3 mask field", rd, 32'h0000_00FE);
    regWr(NA + 2, 32'h0000_0101);
    regRd(NA + 2, rd); check("R3 mask bit0 ignored", rd, 32'h0000_0000);

    // R4 exact match after reset masks, R/W bit ignored
    regWr(1, 32'h0000_00A4);   // address 0x52, gc off
    addrPhase(8'hA5, 0);
    check("R4 exact R/W ignored", outs(), model(8'hA5, 1'b1));
    check("R4 exact hit expected", outs(), 32'h0000_0015);
    regRd(2 * NA, rd); check("R7 data reg", rd, 32'h0000_00A5);
    addrPhase(8'hA6, 0);
    check("R4 one bit off", outs(), 32'd0);

    // R4 mask makes bit don't-care
    regWr(NA + 1, 32'h0000_0002);   // ignore address bit 0 (byte bit 1)
    addrPhase(8'hA6, 0);
    check("R4 masked bit", outs(), 32'h0000_0015);

    // R6 lowest index wins
    regWr(0, 32'h0000_00A0);
    regWr(NA + 0, 32'h0000_000E);
    addrPhase(8'hA6, 0);
    check("R6 lowest index", outs(), 32'h0000_0014);

    // R5 general call: masks all ones, no gc enable -> no match at all
    regWr(NA + 3, 32'h0000_00FE);
    regWr(3, 32'h0000_0000);
    addrPhase(8'h00, 0);
    check("R5 gc disabled", outs(), 32'd0);
    regWr(3, 32'h0000_0001);
    addrPhase(8'h01, 0);
    check("R5 gc enabled", outs(), 32'h0000_0018);

    // R11 clear one cycle after START
    @(negedge clk); startSeen = 1'b1;
    @(negedge clk); startSeen = 1'b0;
    check("R11 cleared on start", outs(), 32'd0);

    // R8 later bytes not compared
    addrPhase(8'hA6, 0);
    hold = outs();
    @(negedge clk); rxByte = 8'h00; byteDone = 1'b1;
    @(negedge clk); byteDone = 1'b0;
    check("R8 second byte ignored", outs(), hold);
    regRd(2 * NA, rd); check("R7 data follows 2nd byte", rd, 32'h0000_0000);

    // R9 ack gating
    ackEnable = 1'b0;
    addrPhase(8'hA6, 0);
    check("R9 no ack", outs(), 32'h0000_0004);
    ackEnable = 1'b1;

    // R10 master owns transfer
    masterOwn = 1'b1;
    addrPhase(8'hA6, 0);
    check("R10 master no compare", outs(), 32'd0);
    addrPhase(8'hA6, 1);
    check("R10 arb lost compares", outs(), 32'h0000_0014);
    masterOwn = 1'b0;

    // random phase, R4/R5/R6/R9
    for (int n = 0; n < 60; n++) begin
      for (int i = 0; i < NA; i++) begin
        regWr(i, $urandom());
        regWr(NA + i, $urandom() & $urandom() & $urandom());
      end
      ackEnable = 1'($urandom());
      for (int k = 0; k < 4; k++) begin
        case ($urandom_range(0, 3))
          0: rx = 8'($urandom());
          1: rx = {7'd0, 1'($urandom())};
          default: begin
            int s = $urandom_range(0, NA - 1);
            rx = {mAddr[s][7:1] ^ (7'($urandom()) & mMask[s]), 1'($urandom())};
          end
        endcase
        addrPhase(rx, 0);
        check("R4/R5/R6/R9 random", outs(), model(rx, ackEnable));
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule